// File: doc/BRIEF.md
# Two-Best Track Selector with Neighbour Duplicate Removal

This block receives one event's worth of muon track candidates every clock: twelve slots, two from each of six side-by-side track finders. Finders that sit next to each other can rebuild the same physical muon from the same chamber segments. That would make one muon look like two. The block first removes these duplicates. A candidate is dropped when a finder next to its own has a better candidate that uses one of the same segments.

The surviving candidates are then ranked all at once. Each pair of candidates is compared in parallel, and each candidate counts how many others beat it. The unbeaten candidate is reported as the best track, and the candidate beaten exactly once is reported as the second. A new event can be accepted every cycle, and its result appears after a fixed two-register latency.

Top module: `trk_top2_sorter`

## Requirements
- R1: A candidate's rank is bits [30:28] (quality) placed above bits [27:23] (transverse momentum) of its 31-bit word, compared as an 8-bit unsigned number, so quality dominates momentum. The best output carries the word of the highest-ranked surviving candidate.
- R2: The second output carries the word of the surviving candidate with the next-highest rank.
- R3: When two surviving candidates have equal rank, the one in the lower-numbered input slot is ordered ahead.
- R4: best_valid_o is 1 when at least one candidate survives, and second_valid_o is 1 when at least two survive. An output whose valid flag is 0 carries an all-zero word.
- R5: Slot i belongs to finder i/2. Each slot has four 4-bit segment addresses, one per station, with station s at cand_seg_i[(i*4+s)*4 +: 4]. Two valid candidates are duplicates when their finders differ by exactly one and, at some station, they hold the same nonzero address. The lower-ranked candidate of such a pair is removed. If their ranks are equal, the one in the higher-numbered slot is removed.
- R6: Candidates from the same finder, or from finders that are not next to each other, are never removed as duplicates, even when they share segment addresses.
- R7: A segment address of 0 means "no segment" and never counts as a match. Addresses match only when they are at the same station.
- R8: A candidate set applied before clock edge k appears on the outputs after edge k+1. A different set may be applied at every edge.
- R9: While rst_n is low at a clock edge, both valid outputs and both output words become zero.
- R10: A candidate with its valid flag at 0 is ignored. It never appears on an output and never removes another candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cand_valid_i | input | 12 | Valid flag per candidate slot |
| cand_word_i | input | 372 | Twelve 31-bit track words, slot i at [i*31 +: 31] |
| cand_seg_i | input | 192 | Four 4-bit segment addresses per slot |
| best_valid_o | output | 1 | Best track present |
| best_word_o | output | 31 | Best track word |
| second_valid_o | output | 1 | Second track present |
| second_word_o | output | 31 | Second track word |

## Verification
The checker enforces several rules on every cycle:
- the best output never ranks below the second;
- a second result never appears without a best one;
- invalid outputs are all-zero;
- the surviving-candidate mask never holds a slot that was not valid at the input;
- an empty input cycle produces no result two edges later.

Some behaviours depend on which words should have come out, and only the directed scenarios can show them:
- which candidate wins;
- how ties are broken;
- whether a duplicate was removed or correctly kept, including the cases with same finder, distant finders, zero addresses and invalid slots;
- the exact latency.

// File: rtl/trk_sort_pkg.sv
// Package: shared word layout, rank type and the pairwise "beats" relation.
// Assumes the rank field sits in the top bits of each track word.
package trk_sort_pkg;

    localparam int unsigned WORD_W = 31;
    localparam int unsigned QUAL_W = 3;
    localparam int unsigned PT_W   = 5;
    localparam int unsigned RANK_W = QUAL_W + PT_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RANK_W-1:0] rank_t;

    typedef struct packed {
        logic  vld;
        word_t word;
    } slot_t;

    // Extract the rank (quality above momentum) from a track word.
    function automatic rank_t rank_of(input word_t w);
        return w[WORD_W-1 -: RANK_W];
    endfunction

    // True when candidate a is ordered ahead of candidate b; ties go to lower slot.
    function automatic logic beats(input rank_t ra, input int ia,
                                   input rank_t rb, input int ib);
        return (ra > rb) || ((ra == rb) && (ia < ib));
    endfunction

endpackage

// File: rtl/trk_ghost_kill.sv
// Module: removes duplicate candidates built by neighbouring finders.
// Combinational. A candidate is cleared when a valid candidate from an
// adjacent finder shares a nonzero segment address at the same station and
// beats it. Decisions use the raw valid flags, so all pairs resolve in parallel.
module trk_ghost_kill
    import trk_sort_pkg::*;
#(
    parameter int unsigned N_CAND     = 12,
    parameter int unsigned PER_FINDER = 2,
    parameter int unsigned N_STN      = 4,
    parameter int unsigned SEG_W      = 4
) (
    input  logic [N_CAND-1:0]             valid_i,
    input  rank_t                         rank_i [N_CAND],
    input  logic [N_CAND*N_STN*SEG_W-1:0] seg_i,
    output logic [N_CAND-1:0]             kept_o
);

    logic [SEG_W-1:0] seg [N_CAND][N_STN];
    logic [N_CAND-1:0] kill;

    // Unpack the flat segment bus into a slot-by-station array.
    for (genvar c = 0; c < N_CAND; c++) begin : g_slot
        for (genvar s = 0; s < N_STN; s++) begin : g_stn
            assign seg[c][s] = seg_i[(c*N_STN + s)*SEG_W +: SEG_W];
        end
    end

    // Mark every candidate that loses to an overlapping neighbour.
    always_comb begin
        kill = '0;
        for (int i = 0; i < N_CAND; i++) begin
            for (int j = 0; j < N_CAND; j++) begin
                int  fi;
                int  fj;
                logic hit;
                fi  = i / PER_FINDER;
                fj  = j / PER_FINDER;
                hit = 1'b0;
                for (int s = 0; s < N_STN; s++) begin
                    if ((seg[i][s] != '0) && (seg[i][s] == seg[j][s])) begin
                        hit = 1'b1;
                    end
                end
                if ((fi - fj == 1 || fj - fi == 1) && valid_i[i] && valid_i[j]
                    && hit && beats(rank_i[j], j, rank_i[i], i)) begin
                    kill[i] = 1'b1;
                end
            end
        end
    end

    assign kept_o = valid_i & ~kill;

endmodule

// File: rtl/trk_rank_net.sv
// Module: fully parallel top-two selector.
// Combinational. For every candidate it counts the valid candidates that
// beat it. A count of zero marks the best candidate and a count of one marks
// the second. The order is total, so each selection is one-hot or empty.
module trk_rank_net
    import trk_sort_pkg::*;
#(
    parameter int unsigned N_CAND = 12
) (
    input  logic [N_CAND-1:0] valid_i,
    input  word_t             word_i [N_CAND],
    output slot_t             first_o,
    output slot_t             second_o
);

    localparam int unsigned CNT_W = $clog2(N_CAND + 1);

    rank_t             rank [N_CAND];
    logic [CNT_W-1:0]  lost [N_CAND];
    logic [N_CAND-1:0] sel0;
    logic [N_CAND-1:0] sel1;

    for (genvar c = 0; c < N_CAND; c++) begin : g_cand
        assign rank[c] = rank_of(word_i[c]);

        // Count how many valid candidates are ordered ahead of this one.
        always_comb begin
            lost[c] = '0;
            for (int j = 0; j < N_CAND; j++) begin
                if (j != c && valid_i[j] && beats(rank[j], j, rank[c], c)) begin
                    lost[c] = lost[c] + 1'b1;
                end
            end
        end

        assign sel0[c] = valid_i[c] && (lost[c] == CNT_W'(0));
        assign sel1[c] = valid_i[c] && (lost[c] == CNT_W'(1));
    end

    // AND-OR multiplex the selected words onto the two result slots.
    always_comb begin
        first_o  = '0;
        second_o = '0;
        for (int c = 0; c < N_CAND; c++) begin
            if (sel0[c]) first_o  = '{vld: 1'b1, word: word_i[c]};
            if (sel1[c]) second_o = '{vld: 1'b1, word: word_i[c]};
        end
    end

endmodule

// File: rtl/trk_top2_sorter.sv
// Module: two-stage duplicate removal and top-two selection.
// Stage 1 registers the candidate words together with the mask of candidates
// that survive duplicate removal. Stage 2 ranks the survivors and registers
// the two results. Latency is two clocks, throughput is one event per clock.
// Reset is synchronous and active low.
module trk_top2_sorter
    import trk_sort_pkg::*;
#(
    parameter int unsigned N_FINDERS  = 6,
    parameter int unsigned PER_FINDER = 2,
    parameter int unsigned N_STN      = 4,
    parameter int unsigned SEG_W      = 4
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [N_FINDERS*PER_FINDER-1:0]                     cand_valid_i,
    input  logic [N_FINDERS*PER_FINDER*WORD_W-1:0]              cand_word_i,
    input  logic [N_FINDERS*PER_FINDER*N_STN*SEG_W-1:0]         cand_seg_i,
    output logic                                                best_valid_o,
    output logic [WORD_W-1:0]                                   best_word_o,
    output logic                                                second_valid_o,
    output logic [WORD_W-1:0]                                   second_word_o
);

    localparam int unsigned N_CAND = N_FINDERS * PER_FINDER;

    word_t             word_in [N_CAND];
    rank_t             rank_in [N_CAND];
    logic [N_CAND-1:0] kept;
    word_t             word_q  [N_CAND];
    logic [N_CAND-1:0] kept_q;
    slot_t             first_c;
    slot_t             second_c;
    slot_t             first_q;
    slot_t             second_q;

    for (genvar c = 0; c < N_CAND; c++) begin : g_in
        assign word_in[c] = cand_word_i[c*WORD_W +: WORD_W];
        assign rank_in[c] = rank_of(word_in[c]);
    end

    trk_ghost_kill #(
        .N_CAND     (N_CAND),
        .PER_FINDER (PER_FINDER),
        .N_STN      (N_STN),
        .SEG_W      (SEG_W)
    ) ghost_i (
        .valid_i (cand_valid_i),
        .rank_i  (rank_in),
        .seg_i   (cand_seg_i),
        .kept_o  (kept)
    );

    // Stage 1: capture the words and the duplicate-free valid mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q <= '0;
            for (int c = 0; c < N_CAND; c++) word_q[c] <= '0;
        end else begin
            kept_q <= kept;
            for (int c = 0; c < N_CAND; c++) word_q[c] <= word_in[c];
        end
    end

    trk_rank_net #(
        .N_CAND (N_CAND)
    ) rank_i (
        .valid_i  (kept_q),
        .word_i   (word_q),
        .first_o  (first_c),
        .second_o (second_c)
    );

    // Stage 2: capture the two selected tracks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            first_q  <= first_c;
            second_q <= second_c;
        end
    end

    assign best_valid_o   = first_q.vld;
    assign best_word_o    = first_q.word;
    assign second_valid_o = second_q.vld;
    assign second_word_o  = second_q.word;

endmodule

// File: rtl/trk_top2_sorter_chk.sv
// Module: assertion checker bound to trk_top2_sorter.
// Assumes the word layout in trk_sort_pkg. It counts cycles since reset so
// that no property looks back past the reset.
module trk_top2_sorter_chk
    import trk_sort_pkg::*;
#(
    parameter int unsigned N_CAND = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CAND-1:0] cand_valid_i,
    input logic [N_CAND-1:0] kept_q,
    input logic              best_valid_o,
    input logic [WORD_W-1:0] best_word_o,
    input logic              second_valid_o,
    input logic [WORD_W-1:0] second_word_o
);

    logic [1:0] since_rst;

    // Count clocks since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid_o && second_valid_o) |->
            (rank_of(best_word_o) >= rank_of(second_word_o))); // R2

    AST_SECOND_NEEDS_BEST: assert property (@(posedge clk) disable iff (!rst_n)
        second_valid_o |-> best_valid_o); // R4

    AST_IDLE_BEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid_o |-> (best_word_o == '0)); // R4

    AST_IDLE_SECOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !second_valid_o |-> (second_word_o == '0)); // R4

    AST_KEPT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> ((kept_q & ~$past(cand_valid_i)) == '0)); // R10

    AST_EMPTY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(cand_valid_i, 2) == '0) |-> !best_valid_o); // R8

endmodule

bind trk_top2_sorter trk_top2_sorter_chk #(
    .N_CAND (N_CAND)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cand_valid_i   (cand_valid_i),
    .kept_q         (kept_q),
    .best_valid_o   (best_valid_o),
    .best_word_o    (best_word_o),
    .second_valid_o (second_valid_o),
    .second_word_o  (second_word_o)
);

// File: tb/trk_top2_sorter_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module trk_top2_sorter_tb_top;

    localparam int NC = 12;
    localparam int WW = 31;
    localparam int NS = 4;
    localparam int SW = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NC-1:0]       vld = '0;
    logic [NC*WW-1:0]    words = '0;
    logic [NC*NS*SW-1:0] segs = '0;
    logic                bv;
    logic [WW-1:0]       bw;
    logic                sv;
    logic [WW-1:0]       sw;
    int                  checks = 0;
    int                  errors = 0;

    always #10 clk = ~clk;

    trk_top2_sorter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cand_valid_i   (vld),
        .cand_word_i    (words),
        .cand_seg_i     (segs),
        .best_valid_o   (bv),
        .best_word_o    (bw),
        .second_valid_o (sv),
        .second_word_o  (sw)
    );

    function automatic logic [WW-1:0] mk(input int q, input int pt, input int tag);
        return {3'(q), 5'(pt), 23'(tag)};
    endfunction

    task automatic clear_in();
        vld = '0; words = '0; segs = '0;
    endtask

    task automatic put(input int i, input int q, input int pt);
        words[i*WW +: WW] = mk(q, pt, i + 1);
        vld[i] = 1'b1;
    endtask

    task automatic put_seg(input int i, input int s, input int a);
        segs[(i*NS + s)*SW +: SW] = 4'(a);
    endtask

    task automatic chk(input string req, input logic ebv, input logic [WW-1:0] ebw,
                       input logic esv, input logic [WW-1:0] esw);
        checks++;
        if (bv !== ebv || bw !== ebw || sv !== esv || sw !== esw) begin
            errors++;
            $display("FAIL %s: got best %0b/%h second %0b/%h, expected best %0b/%h second %0b/%h",
                     req, bv, bw, sv, sw, ebv, ebw, esv, esw);
        end
    endtask

    // Apply the current inputs and wait until their result is on the outputs.
    task automatic run_set();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R9: outputs stay zero while reset is low, even with valid inputs
        put(0, 7, 31);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R9", 1'b0, '0, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_in();
    endtask

    task automatic t_basic();
        // R1 R2: quality dominates momentum
        clear_in();
        put(3, 5, 2); put(7, 6, 1); put(10, 5, 20);
        run_set();
        chk("R1", 1'b1, mk(6, 1, 8), 1'b1, mk(5, 20, 11));
        clear_in();
        put(0, 1, 1); put(11, 2, 0); put(6, 1, 30);
        run_set();
        chk("R2", 1'b1, mk(2, 0, 12), 1'b1, mk(1, 30, 7));
    endtask

    task automatic t_tie();
        // R3: equal ranks, lower slot first
        clear_in();
        put(9, 3, 4); put(2, 3, 4); put(5, 1, 0);
        run_set();
        chk("R3", 1'b1, mk(3, 4, 3), 1'b1, mk(3, 4, 10));
    endtask

    task automatic t_count();
        // R4: one survivor, then none
        clear_in();
        put(4, 2, 2);
        run_set();
        chk("R4 single", 1'b1, mk(2, 2, 5), 1'b0, '0);
        clear_in();
        run_set();
        chk("R4 empty", 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_ghost();
        // R5: adjacent finders share station 1 address 7; lower rank dropped
        clear_in();
        put(1, 6, 0); put(2, 4, 0); put(8, 2, 0);
        put_seg(1, 1, 7); put_seg(2, 1, 7);
        run_set();
        chk("R5 rank", 1'b1, mk(6, 0, 2), 1'b1, mk(2, 0, 9));
        // R5: equal rank, higher slot dropped
        clear_in();
        put(3, 5, 5); put(4, 5, 5); put(11, 1, 1);
        put_seg(3, 3, 9); put_seg(4, 3, 9);
        run_set();
        chk("R5 tie", 1'b1, mk(5, 5, 4), 1'b1, mk(1, 1, 12));
    endtask

    task automatic t_keep();
        // R6: same finder sharing a segment, both kept
        clear_in();
        put(0, 4, 0); put(1, 3, 0);
        put_seg(0, 2, 5); put_seg(1, 2, 5);
        run_set();
        chk("R6 same", 1'b1, mk(4, 0, 1), 1'b1, mk(3, 0, 2));
        // R6: finders 0 and 3 sharing a segment, both kept
        clear_in();
        put(0, 4, 0); put(6, 3, 0);
        put_seg(0, 0, 12); put_seg(6, 0, 12);
        run_set();
        chk("R6 far", 1'b1, mk(4, 0, 1), 1'b1, mk(3, 0, 7));
    endtask

    task automatic t_zero_seg();
        // R7: adjacent candidates whose addresses are zero, or equal but at different stations
        clear_in();
        put(1, 5, 0); put(2, 4, 0);
        put_seg(1, 0, 6); put_seg(2, 2, 6);
        run_set();
        chk("R7", 1'b1, mk(5, 0, 2), 1'b1, mk(4, 0, 3));
    endtask

    task automatic t_invalid();
        // R10: invalid slot 5 is high-ranked and overlaps valid slot 6; it is ignored
        clear_in();
        words[5*WW +: WW] = mk(7, 31, 6);
        put(6, 2, 0); put(0, 1, 0);
        put_seg(5, 1, 3); put_seg(6, 1, 3);
        run_set();
        chk("R10", 1'b1, mk(2, 0, 7), 1'b1, mk(1, 0, 1));
    endtask

    task automatic t_pipe();
        // R8: back-to-back sets, each appearing two edges after it is applied
        clear_in();
        @(negedge clk);
        put(2, 7, 0); put(3, 6, 0);
        @(negedge clk);
        clear_in();
        put(9, 1, 0);
        @(negedge clk);
        chk("R8 first", 1'b1, mk(7, 0, 3), 1'b1, mk(6, 0, 4));
        clear_in();
        @(negedge clk);
        chk("R8 second", 1'b1, mk(1, 0, 10), 1'b0, '0);
        @(negedge clk);
        chk("R8 drain", 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_tie();
        t_count();
        t_ghost();
        t_keep();
        t_zero_seg();
        t_invalid();
        t_pipe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule